// File: doc/BRIEF.md
# Rotating Test-Pattern Word Store

This block keeps eight 48-bit pattern words that configuration software fills one byte at a time. A configuration field carries one 8-bit chunk. A separate flag marks that chunk as new. Each new chunk lands at the current write position, and that position then moves on. A run of writes can therefore reach every byte of every cell without any explicit address.

When the pattern-request field is set, the block plays its cells out on a 48-bit output with a valid flag. It starts at cell 0 and goes up in order, and a downstream ready signal paces it. Playback always covers complete passes of all eight cells. The stream built from the pattern is therefore always a whole multiple of eight words. Bit 47 of every emitted word is forced low, so the words look like ordinary hit data to the stages that follow.

Top module: `testpat_rotfifo`

## Requirements
- R1: After reset, `outValid` is 0, all cells hold zero, and the write position is cell 0, chunk 0.
- R2: A chunk is written only on a rising edge of `cfgNewData`. Holding the flag high for many cycles writes exactly one chunk.
- R3: Six writes fill one cell, least significant chunk first: write k goes to bits [8k+7:8k]. After the sixth chunk the write position moves to chunk 0 of the next cell.
- R4: The write position wraps from cell 7 to cell 0. The ninth cell's worth of writes overwrites cell 0.
- R5: When `cfgPatternReq` is 1 while idle, `outValid` is 1 in the next cycle. Playback starts at cell 0, and each accepted word (valid and ready) advances to the next higher cell.
- R6: Every emitted word has bit 47 equal to 0 and bits 46..0 equal to bits 46..0 of the cell being read.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outWord` stays unchanged in the next cycle, unless a chunk write occurs.
- R8: If `cfgPatternReq` drops partway through a pass, the remaining cells of that pass are still emitted, and `outValid` then falls. The number of accepted words between the rise and fall of `outValid` is a multiple of 8.
- R9: If `cfgPatternReq` is still 1 when cell 7 is accepted, the next pass follows at once, starting again at cell 0, with no gap.
- R10: While idle with `cfgPatternReq` at 0, `outValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPatternReq | input | 1 | Request to play the stored pattern |
| cfgPatternData | input | 8 | Pattern chunk to be written |
| cfgNewData | input | 1 | New-chunk flag; its rising edge commits a write |
| outReady | input | 1 | Downstream accepts the current word |
| outWord | output | 48 | Pattern word being offered |
| outValid | output | 1 | `outWord` is valid |

## Verification
The first pattern set is eight distinct words that include set and clear bit 47, alternating bits and byte-ordered values. Read back through playback, it shows whether chunks landed in the right byte order and the right cell, and whether bit 47 is masked.

The playback timing is tried in four ways:
- a single pass shows the start and stop behaviour;
- a pass with the request held shows the immediate restart at cell 0;
- a pass whose request drops after the second word shows that the pass is completed;
- a stalled pass shows that the output word holds.

The write side is tried in three ways:
- a long-held new-data flag tells edge-triggered writing apart from level-triggered writing;
- a further cell's worth of writes after a full load shows the wrap to cell 0;
- a single extra write shows the move into the next cell.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int TP_CELLS   = 8;
  localparam int TP_WORD_W  = 48;
  localparam int TP_CHUNK_W = 8;
  localparam int TP_CHUNKS  = TP_WORD_W / TP_CHUNK_W;
  localparam int TP_CELL_W  = $clog2(TP_CELLS);
  localparam int TP_POS_W   = $clog2(TP_CHUNKS);

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [TP_CELL_W-1:0] wrCell;
    logic [TP_POS_W-1:0]  wrChunk;
    logic [TP_CELL_W-1:0] rdCell;
  } tpfCtl_t;
endpackage

// File: rtl/tpf_store.sv
module tpf_store
  import tpf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  tpfCtl_t               ctl,
  input  logic [TP_CHUNK_W-1:0] chunkIn,
  output logic [TP_WORD_W-1:0]  wordOut
);
  logic [TP_WORD_W-1:0] cellQ [TP_CELLS];

  for (genvar c = 0; c < TP_CELLS; c++) begin : g_cell
    for (genvar k = 0; k < TP_CHUNKS; k++) begin : g_chunk
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cellQ[c][k*TP_CHUNK_W +: TP_CHUNK_W] <= '0;
        else if (ctl.wrEn && ctl.wrCell == TP_CELL_W'(c) && ctl.wrChunk == TP_POS_W'(k))
          cellQ[c][k*TP_CHUNK_W +: TP_CHUNK_W] <= chunkIn;
      end
    end
  end

  // top bit cleared so words read as data words
  assign wordOut = {1'b0, cellQ[ctl.rdCell][TP_WORD_W-2:0]};
endmodule

// File: rtl/tpf_ctrl.sv
module tpf_ctrl
  import tpf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    patternReq,
  input  logic    newData,
  input  logic    ready,
  output tpfCtl_t ctl,
  output logic    valid
);
  localparam logic [TP_POS_W-1:0]  LAST_CHUNK = TP_POS_W'(TP_CHUNKS - 1);
  localparam logic [TP_CELL_W-1:0] LAST_CELL  = TP_CELL_W'(TP_CELLS - 1);

  logic                 newPrev;
  logic                 wrStrobe;
  logic [TP_CELL_W-1:0] wrCell;
  logic [TP_POS_W-1:0]  wrChunk;
  logic                 active;
  logic [TP_CELL_W-1:0] rdCell;
  logic                 accept;

  assign wrStrobe = newData & ~newPrev;
  assign accept   = active & ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newPrev <= 1'b0;
      wrCell  <= '0;
      wrChunk <= '0;
    end else begin
      newPrev <= newData;
      if (wrStrobe) begin
        if (wrChunk == LAST_CHUNK) begin
          wrChunk <= '0;
          wrCell  <= wrCell + 1'b1;
        end else begin
          wrChunk <= wrChunk + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      rdCell <= '0;
    end else if (accept) begin
      if (rdCell == LAST_CELL) begin
        rdCell <= '0;
        active <= patternReq;
      end else begin
        rdCell <= rdCell + 1'b1;
      end
    end else if (!active && patternReq) begin
      active <= 1'b1;
      rdCell <= '0;
    end
  end

  always_comb begin
    ctl.wrEn    = wrStrobe;
    ctl.wrCell  = wrCell;
    ctl.wrChunk = wrChunk;
    ctl.rdCell  = rdCell;
  end

  assign valid = active;
endmodule

// File: rtl/testpat_rotfifo.sv
module testpat_rotfifo
  import tpf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgPatternReq,
  input  logic [TP_CHUNK_W-1:0] cfgPatternData,
  input  logic                  cfgNewData,
  input  logic                  outReady,
  output logic [TP_WORD_W-1:0]  outWord,
  output logic                  outValid
);
  tpfCtl_t ctl;

  tpf_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .patternReq (cfgPatternReq),
    .newData    (cfgNewData),
    .ready      (outReady),
    .ctl        (ctl),
    .valid      (outValid)
  );

  tpf_store store_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .chunkIn (cfgPatternData),
    .wordOut (outWord)
  );
endmodule

// File: rtl/testpat_rotfifo_chk.sv
module testpat_rotfifo_chk
  import tpf_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgPatternReq,
  input logic                 cfgNewData,
  input logic                 outReady,
  input logic [TP_WORD_W-1:0] outWord,
  input logic                 outValid
);
  logic [TP_CELL_W-1:0] acceptCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptCnt <= '0;
    else if (outValid && outReady) acceptCnt <= acceptCnt + 1'b1;
  end

  a_r6_msb_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !outWord[TP_WORD_W-1]);

  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !cfgNewData) |=> $stable(outWord));

  a_r8_whole_pass: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> acceptCnt == '0);

  a_r5_start: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && cfgPatternReq) |=> outValid);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !cfgPatternReq) |=> !outValid);
endmodule

bind testpat_rotfifo testpat_rotfifo_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .cfgPatternReq (cfgPatternReq),
  .cfgNewData    (cfgNewData),
  .outReady      (outReady),
  .outWord       (outWord),
  .outValid      (outValid)
);

// File: tb/testpat_rotfifo_tb_top.sv
module testpat_rotfifo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgPatternReq = 1'b0;
  logic [7:0]  cfgPatternData = '0;
  logic        cfgNewData = 1'b0;
  logic        outReady = 1'b1;
  logic [47:0] outWord;
  logic        outValid;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [47:0] mexp [8];
  int mCell = 0;
  int mChunk = 0;

  localparam logic [47:0] VEC [8] = '{
    48'hA1B2C3D4E5F6, 48'h800000000001, 48'h7FFFFFFFFFFF, 48'h0123456789AB,
    48'hFEDCBA987654, 48'h555555555555, 48'hAAAAAAAAAAAA, 48'h000000FF0000
  };

  always #2.5 clk = ~clk;

  testpat_rotfifo dut_i (
    .clk(clk), .rstN(rstN), .cfgPatternReq(cfgPatternReq),
    .cfgPatternData(cfgPatternData), .cfgNewData(cfgNewData),
    .outReady(outReady), .outWord(outWord), .outValid(outValid)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finishRun();
      end
    end
  end

  task automatic modelWrite(input logic [7:0] b);
    mexp[mCell][mChunk*8 +: 8] = b;
    if (mChunk == 5) begin
      mChunk = 0;
      mCell = (mCell + 1) % 8;
    end else begin
      mChunk++;
    end
  endtask

  task automatic writeChunk(input logic [7:0] b);
    @(negedge clk);
    cfgPatternData = b;
    cfgNewData = 1'b1;
    @(negedge clk);
    cfgNewData = 1'b0;
    modelWrite(b);
  endtask

  task automatic expectWord(input int idx, input string req);
    @(negedge clk);
    chk(outValid && outWord == {1'b0, mexp[idx][46:0]}, req, outWord, {1'b0, mexp[idx][46:0]});
  endtask

  task automatic expectIdle(input string req);
    @(negedge clk);
    chk(!outValid, req, {47'b0, outValid}, 48'd0);
  endtask

  task automatic startReq();
    @(negedge clk);
    cfgPatternReq = 1'b1;
    outReady = 1'b1;
  endtask

  // words from..7 with request already low, then idle
  task automatic drain(input int from, input string req);
    for (int i = from; i < 8; i++) expectWord(i, req);
    expectIdle(req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mexp[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid, "R1 reset valid", {47'b0, outValid}, 48'd0);

    // R1: storage cleared after reset
    startReq();
    expectWord(0, "R1 cleared cell");
    cfgPatternReq = 1'b0;
    drain(1, "R1 cleared pass");

    // R10: no output while idle
    for (int i = 0; i < 4; i++) expectIdle("R10 idle");

    // table walk: load all cells (R3 byte order, R1 start at cell 0)
    for (int v = 0; v < 8; v++)
      for (int k = 0; k < 6; k++) writeChunk(VEC[v][k*8 +: 8]);
    startReq();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      chk(outValid && outWord == {1'b0, VEC[v][46:0]}, "R3 R5 R6 table", outWord, {1'b0, VEC[v][46:0]});
      if (v == 7) cfgPatternReq = 1'b0;
    end
    expectIdle("R8 single pass end");

    // R9: request held, back-to-back passes
    startReq();
    for (int i = 0; i < 8; i++) expectWord(i, "R9 first pass");
    expectWord(0, "R9 restart cell0");
    cfgPatternReq = 1'b0;
    drain(1, "R9 second pass");

    // R8: drop request after the second word
    startReq();
    expectWord(0, "R8 drop");
    expectWord(1, "R8 drop");
    cfgPatternReq = 1'b0;
    drain(2, "R8 finish pass");

    // R7: stall
    startReq();
    expectWord(0, "R7 before stall");
    cfgPatternReq = 1'b0;
    outReady = 1'b0;
    expectWord(0, "R7 stalled");
    expectWord(0, "R7 stalled");
    outReady = 1'b1;
    drain(1, "R7 after stall");

    // R2: long-held flag writes once (pointer now cell0 chunk0)
    @(negedge clk);
    cfgPatternData = 8'h3C;
    cfgNewData = 1'b1;
    repeat (5) @(negedge clk);
    cfgNewData = 1'b0;
    modelWrite(8'h3C);
    // R4: complete cell 0 again after wrap
    writeChunk(8'h11); writeChunk(8'h22); writeChunk(8'h33);
    writeChunk(8'h44); writeChunk(8'h55);
    // R3: next write goes to cell 1 chunk 0
    writeChunk(8'h99);
    startReq();
    @(negedge clk);
    chk(outValid && outWord == 48'h55443322113C, "R2 R4 wrapped cell0", outWord, 48'h55443322113C);
    cfgPatternReq = 1'b0;
    @(negedge clk);
    chk(outValid && outWord == {1'b0, VEC[1][46:8], 8'h99}, "R3 next cell", outWord, {1'b0, VEC[1][46:8], 8'h99});
    drain(2, "R4 rest");

    finishRun();
  end
endmodule